// File: doc/BRIEF.md
# Region Freeze Bridge Controller

This block lets software isolate a reconfigurable logic region from the static-side bus. Software first asks for a freeze. The block raises the region freeze output at once and keeps the region "unfreeze complete" until the region reports that no transactions remain outstanding. Only then does it report "freeze complete". Once frozen, software may hold the region in reset through a control bit. It later asks for an unfreeze, which drops the freeze and the region reset together. The block reports "unfreeze complete" one cycle after that.

Software sees four 32-bit word registers. Word index 0 (byte offset 0) is status. Word index 1 (byte offset 4) is control. Word index 2 (byte offset 8) is the sticky illegal-request record. Word index 3 (byte offset 12) is a read-only version word. A request bit takes effect only on the write that changes it from 0 to 1. A request that does not match the current state is rejected: it leaves the state unchanged and is recorded in the illegal-request register.

The core is a four-state machine:
- THAW: traffic is passing.
- DRAIN: the freeze is up and outstanding transactions are being waited out.
- FROZEN: the drain has completed.
- RESUME: the freeze has just been released.

The transitions are:
- THAW→DRAIN on a legal freeze request.
- DRAIN→FROZEN when the outstanding count is zero.
- FROZEN→RESUME on a legal unfreeze request.
- RESUME→THAW unconditionally after one cycle.

Top module: `frz_bridge_ctl`

## Requirements
- R1: After reset the state is THAW and the registers read as follows. Status reads 2. Control reads 0. The illegal-request register reads 0. Both `region_freeze` and `region_rst` are low.
- R2: Status bit 0 is freeze-complete and status bit 1 is unfreeze-complete. At most one of them is set at a time. Writes to status have no effect.
- R3: In THAW, a control write that moves bit 0 from 0 to 1 raises `region_freeze` on the following cycle. Unfreeze-complete stays set while `pend_cnt` is nonzero.
- R4: In DRAIN, the first clock edge that samples `pend_cnt` equal to zero sets freeze-complete and clears unfreeze-complete, so status reads 1. `region_freeze` stays high.
- R5: `region_rst` is high exactly while control bit 1 is set and the state is FROZEN. Setting bit 1 in THAW leaves `region_rst` low.
- R6: In FROZEN, a control write that moves bit 2 from 0 to 1 drops `region_freeze` and `region_rst` on the next cycle, while status still reads 1. One cycle later status reads 2.
- R7: Rewriting a request bit that is already set causes no transition and records no illegal request.
- R8: A freeze request outside THAW sets illegal bit 0. An unfreeze request outside FROZEN sets illegal bit 1. In both cases the state is unchanged, and both bits stay set until cleared.
- R9: Writing a value with bit 0 set to the illegal-request register clears it to 0. Writing a value with bit 0 clear leaves it unchanged.
- R10: The version word reads 2 by default, or 0xAD000003 when `USE_ALT_ID` is 1. Writes to it have no effect.
- R11: Control reads back the full 32-bit value last written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Word index (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of `bus_rd`, zero otherwise |
| region_freeze | output | 1 | Stops new transactions into the region |
| region_rst | output | 1 | Holds the region in reset |
| pend_cnt | input | CNT_W | Outstanding transaction count from the region |

## Verification
A wrong state register shows up at the ports within one cycle of the write that should have moved it. It appears either as a status word with the wrong done bit or as a freeze or reset output at the wrong level, because all three are decoded directly from the state. A broken legality check or edge detector surfaces as an illegal-request bit that appears or fails to appear on the next read. A drain that completes early is caught by reading status while the outstanding count is still held nonzero.

// File: rtl/frz_pkg.sv
package frz_pkg;
    localparam int REG_W = 32;
    localparam int IDX_W = 2;

    localparam logic [IDX_W-1:0] IDX_STATUS  = 2'd0;
    localparam logic [IDX_W-1:0] IDX_CTRL    = 2'd1;
    localparam logic [IDX_W-1:0] IDX_ILLEGAL = 2'd2;
    localparam logic [IDX_W-1:0] IDX_VERSION = 2'd3;

    localparam logic [REG_W-1:0] VER_BASE = 32'h0000_0002;
    localparam logic [REG_W-1:0] VER_ALT  = 32'hAD00_0003;

    typedef enum logic [1:0] {
        ST_THAW,
        ST_DRAIN,
        ST_FROZEN,
        ST_RESUME
    } frz_state_e;
endpackage

// File: rtl/frz_fsm.sv
module frz_fsm
    import frz_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_frz,
    input  logic req_unf,
    input  logic rst_hold,
    input  logic pend_zero,
    output logic sts_fd,
    output logic sts_ud,
    output logic region_freeze,
    output logic region_rst,
    output logic ill_frz,
    output logic ill_unf
);
    frz_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_THAW;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_THAW:   if (req_frz)   state_d = ST_DRAIN;
            ST_DRAIN:  if (pend_zero) state_d = ST_FROZEN;
            ST_FROZEN: if (req_unf)   state_d = ST_RESUME;
            ST_RESUME:                state_d = ST_THAW;
            default:                  state_d = ST_THAW;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        sts_fd        = 1'b0;
        sts_ud        = 1'b0;
        region_freeze = 1'b0;
        region_rst    = 1'b0;
        unique case (state_q)
            ST_THAW:   sts_ud = 1'b1;
            ST_DRAIN: begin
                sts_ud        = 1'b1;
                region_freeze = 1'b1;
            end
            ST_FROZEN: begin
                sts_fd        = 1'b1;
                region_freeze = 1'b1;
                region_rst    = rst_hold;
            end
            ST_RESUME: sts_fd = 1'b1;
            default:   sts_ud = 1'b1;
        endcase
        ill_frz = req_frz && (state_q != ST_THAW);
        ill_unf = req_unf && (state_q != ST_FROZEN);
    end
endmodule

// File: rtl/frz_csr.sv
module frz_csr
    import frz_pkg::*;
#(
    parameter logic [REG_W-1:0] VERSION_ID = VER_BASE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [IDX_W-1:0] bus_addr,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    input  logic             sts_fd,
    input  logic             sts_ud,
    input  logic             ill_frz,
    input  logic             ill_unf,
    output logic             req_frz,
    output logic             req_unf,
    output logic             rst_hold,
    output logic [REG_W-1:0] ctrl_q,
    output logic [1:0]       ill_q
);
    logic wr_ctrl, wr_ill, ill_clr;

    assign wr_ctrl = bus_wr && (bus_addr == IDX_CTRL);
    assign wr_ill  = bus_wr && (bus_addr == IDX_ILLEGAL);
    assign ill_clr = wr_ill && bus_wdata[0];

    // requests act only on a 0->1 change of their bit
    assign req_frz  = wr_ctrl && bus_wdata[0] && !ctrl_q[0];
    assign req_unf  = wr_ctrl && bus_wdata[2] && !ctrl_q[2];
    assign rst_hold = ctrl_q[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= bus_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ill_q <= '0;
        else if (ill_frz || ill_unf) ill_q <= ill_q | {ill_unf, ill_frz};
        else if (ill_clr) ill_q <= '0;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (bus_addr)
                IDX_STATUS:  bus_rdata = {{(REG_W-2){1'b0}}, sts_ud, sts_fd};
                IDX_CTRL:    bus_rdata = ctrl_q;
                IDX_ILLEGAL: bus_rdata = {{(REG_W-2){1'b0}}, ill_q};
                IDX_VERSION: bus_rdata = VERSION_ID;
                default:     bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/frz_bridge_ctl.sv
module frz_bridge_ctl
    import frz_pkg::*;
#(
    parameter bit USE_ALT_ID = 1'b0,
    parameter int CNT_W      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [IDX_W-1:0] bus_addr,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    output logic             region_freeze,
    output logic             region_rst,
    input  logic [CNT_W-1:0] pend_cnt
);
    localparam logic [REG_W-1:0] VERSION_ID = USE_ALT_ID ? VER_ALT : VER_BASE;

    logic             req_frz, req_unf, rst_hold, pend_zero;
    logic             sts_fd, sts_ud, ill_frz, ill_unf;
    logic [REG_W-1:0] ctrl_q;
    logic [1:0]       ill_q;

    assign pend_zero = (pend_cnt == '0);

    frz_csr #(.VERSION_ID(VERSION_ID)) u_csr (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sts_fd(sts_fd), .sts_ud(sts_ud),
        .ill_frz(ill_frz), .ill_unf(ill_unf),
        .req_frz(req_frz), .req_unf(req_unf), .rst_hold(rst_hold),
        .ctrl_q(ctrl_q), .ill_q(ill_q)
    );

    frz_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .req_frz(req_frz), .req_unf(req_unf),
        .rst_hold(rst_hold), .pend_zero(pend_zero),
        .sts_fd(sts_fd), .sts_ud(sts_ud),
        .region_freeze(region_freeze), .region_rst(region_rst),
        .ill_frz(ill_frz), .ill_unf(ill_unf)
    );
endmodule

// File: rtl/frz_bridge_ctl_chk.sv
module frz_bridge_ctl_chk
    import frz_pkg::*;
#(
    parameter int               CNT_W      = 8,
    parameter logic [REG_W-1:0] VERSION_ID = VER_BASE
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic             bus_rd,
    input logic [IDX_W-1:0] bus_addr,
    input logic [REG_W-1:0] bus_wdata,
    input logic [REG_W-1:0] bus_rdata,
    input logic             region_freeze,
    input logic             region_rst,
    input logic [CNT_W-1:0] pend_cnt,
    input logic             sts_fd,
    input logic             sts_ud,
    input logic [REG_W-1:0] ctrl_q,
    input logic [1:0]       ill_q
);
    logic ill_clr_wr;
    assign ill_clr_wr = bus_wr && (bus_addr == IDX_ILLEGAL) && bus_wdata[0];

    p_status_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sts_fd, sts_ud}));

    p_freeze_on_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == IDX_CTRL && bus_wdata[0] && !ctrl_q[0]
         && sts_ud && !region_freeze) |=> region_freeze);

    p_done_after_drain_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_fd) |-> ($past(pend_cnt) == '0) && $past(region_freeze));

    p_reset_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
        region_rst |-> (sts_fd && region_freeze && ctrl_q[1]));

    p_unfreeze_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_ud) |-> (!region_freeze && !region_rst && $past(!region_freeze)));

    p_ill_frz_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ill_q[0] && !ill_clr_wr) |=> ill_q[0]);

    p_ill_unf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ill_q[1] && !ill_clr_wr) |=> ill_q[1]);

    p_ill_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ill_clr_wr |=> (ill_q == 2'b00));

    p_version_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == IDX_VERSION) |-> (bus_rdata == VERSION_ID));
endmodule

bind frz_bridge_ctl frz_bridge_ctl_chk #(.CNT_W(CNT_W), .VERSION_ID(VERSION_ID)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .region_freeze(region_freeze), .region_rst(region_rst), .pend_cnt(pend_cnt),
    .sts_fd(sts_fd), .sts_ud(sts_ud), .ctrl_q(ctrl_q), .ill_q(ill_q)
);

// File: tb/frz_bridge_ctl_bench.sv
module frz_bridge_ctl_bench;
    localparam int CNT_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [1:0]        bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              region_freeze, region_rst;
    logic [CNT_W-1:0]  pend_cnt = '0;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    typedef struct {
        bit          do_rd;
        logic [31:0] exp_data;
        bit          do_pin;
        bit          exp_frz;
        bit          exp_rst;
        string       tag;
    } item_t;

    item_t sb_q[$];
    item_t cur;

    always #5 clk = ~clk;

    frz_bridge_ctl #(.USE_ALT_ID(1'b0), .CNT_W(CNT_W)) u_frz_bridge_ctl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .region_freeze(region_freeze), .region_rst(region_rst), .pend_cnt(pend_cnt)
    );

    // monitor: compares at the falling edge, away from the active edge
    always @(negedge clk) begin
        if (sb_q.size() != 0) begin
            cur = sb_q.pop_front();
            if (cur.do_rd) begin
                checks++;
                if (bus_rdata !== cur.exp_data) begin
                    errors++;
                    $display("FAIL %s rdata actual=%h expected=%h", cur.tag, bus_rdata, cur.exp_data);
                end
            end
            if (cur.do_pin) begin
                checks++;
                if (region_freeze !== cur.exp_frz || region_rst !== cur.exp_rst) begin
                    errors++;
                    $display("FAIL %s pins actual frz=%b rst=%b expected frz=%b rst=%b",
                             cur.tag, region_freeze, region_rst, cur.exp_frz, cur.exp_rst);
                end
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        bus_wr = 1'b0;
    endtask

    // one cycle: optional read and optional pin check, both pushed to the scoreboard
    task automatic chk(input bit rd, input logic [1:0] a, input logic [31:0] e,
                       input bit pin, input bit f, input bit r, input string tag);
        item_t it;
        it.do_rd = rd; it.exp_data = e; it.do_pin = pin;
        it.exp_frz = f; it.exp_rst = r; it.tag = tag;
        bus_rd = rd; bus_addr = a;
        sb_q.push_back(it);
        step();
        bus_rd = 1'b0;
    endtask

    task automatic rdc(input logic [1:0] a, input logic [31:0] e, input string tag);
        chk(1'b1, a, e, 1'b0, 1'b0, 1'b0, tag);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk(1'b1, 2'd0, 32'd2, 1'b1, 1'b0, 1'b0, "R1 status/pins");
        rdc(2'd1, 32'd0, "R1 control");
        rdc(2'd2, 32'd0, "R1 illegal");
        rdc(2'd3, 32'd2, "R10 version");

        // R3 freeze with outstanding traffic
        pend_cnt = 8'd3;
        wr(2'd1, 32'd1);
        chk(1'b1, 2'd0, 32'd2, 1'b1, 1'b1, 1'b0, "R3 freeze up, ud kept");
        rdc(2'd1, 32'd1, "R11 control readback");

        // R8 freeze request while draining
        wr(2'd1, 32'd0);
        wr(2'd1, 32'd1);
        rdc(2'd2, 32'd1, "R8 illegal freeze");
        rdc(2'd0, 32'd2, "R8 state unchanged");

        // R9 clear semantics
        wr(2'd2, 32'd0);
        rdc(2'd2, 32'd1, "R9 write 0 keeps");
        wr(2'd2, 32'd1);
        rdc(2'd2, 32'd0, "R9 write 1 clears");

        // R4 drain completes
        pend_cnt = 8'd0;
        step();
        chk(1'b1, 2'd0, 32'd1, 1'b1, 1'b1, 1'b0, "R4 freeze done");

        // R7 rewrite of a set bit
        wr(2'd1, 32'd1);
        rdc(2'd2, 32'd0, "R7 no illegal on rewrite");
        rdc(2'd0, 32'd1, "R7 still frozen");

        // R5 region reset
        wr(2'd1, 32'd2);
        chk(1'b1, 2'd0, 32'd1, 1'b1, 1'b1, 1'b1, "R5 reset held");
        wr(2'd1, 32'd0);
        chk(1'b0, 2'd0, 32'd0, 1'b1, 1'b1, 1'b0, "R5 reset released");

        // R6 unfreeze
        wr(2'd1, 32'd6);
        chk(1'b1, 2'd0, 32'd1, 1'b1, 1'b0, 1'b0, "R6 release, fd one more cycle");
        rdc(2'd0, 32'd2, "R6 unfreeze done");

        // R8 unfreeze while unfrozen
        wr(2'd1, 32'd0);
        wr(2'd1, 32'd4);
        rdc(2'd2, 32'd2, "R8 illegal unfreeze");
        rdc(2'd0, 32'd2, "R8 still thawed");

        // R5 reset request in THAW has no effect
        wr(2'd1, 32'd2);
        chk(1'b0, 2'd0, 32'd0, 1'b1, 1'b0, 1'b0, "R5 no reset in thaw");

        // R10 / R2 read-only words
        wr(2'd3, 32'd0);
        rdc(2'd3, 32'd2, "R10 version unchanged");
        wr(2'd0, 32'd1);
        rdc(2'd0, 32'd2, "R2 status unchanged");

        // R11 full-width readback
        wr(2'd1, 32'hFFFF_FFF0);
        rdc(2'd1, 32'hFFFF_FFF0, "R11 wide readback");
        wr(2'd1, 32'd0);

        // R4 freeze with nothing outstanding: one drain cycle, then done
        wr(2'd1, 32'd1);
        chk(1'b1, 2'd0, 32'd2, 1'b1, 1'b1, 1'b0, "R4 drain cycle");
        rdc(2'd0, 32'd1, "R4 done next cycle");
        rdc(2'd2, 32'd2, "R8 sticky bit 1 kept");

        step();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule